// File: doc/BRIEF.md
# Audio Link Input Frame Receiver

This block sits on the receive side of an AC97-style audio link. It turns the codec's serial return stream into parallel fields. It runs directly on the link bit clock and samples the serial data and the frame sync on the falling edge. A rising edge of the sync marks the first bit of a frame. A 256-bit counter then places each bit in its slot. A frame is a 16-bit header slot followed by twelve 20-bit slots, each shifted in MSB first.

From the header slot the block takes the codec-ready flag and the twelve slot tags. From the first data slot it takes the echoed register index and the active-low request flags. It holds the request flags for the output side until the next frame. The second slot carries the status word. The block passes it on only when the echoed index matches the address of the last read command, which a controller supplies on a one-cycle issue strobe, and only while that read is still outstanding. Slots 3, 4 and 6 carry the left, right and microphone record samples. The block delivers the upper 16 bits of each one.

Every captured field comes with a valid strobe one bit clock long, just after the last bit of its slot. A sync edge that arrives at the wrong count is reported as a framing error. The counter then realigns to that edge.

Top module: `acrx_top`

## Requirements
- R1: While reset is asserted and after its release, codec_rdy_o, slot_tag_o, rd_pend_o, frame_err_o and every valid strobe are 0, and slot_req_n_o is all ones.
- R2: Frame bit 0 is the serial bit sampled together with the first sampled 1 of sync_i after a sampled 0. Bits 0..15 form the header slot. Bits 16+20(k-1) .. 35+20(k-1) form slot k, MSB first. Before the first sync rise, no field is captured and no strobe is issued.
- R3: Header bit 15 (frame bit 0) appears on codec_rdy_o once the header slot ends. While it is 0, no status strobe and no sample strobe is issued in that frame.
- R4: Header bit 15-k is the tag of slot k and appears on slot_tag_o[k-1]. A status strobe needs the tags of slots 1 and 2 both set. A sample strobe needs the tag of its own slot.
- R5: Slot 1 bits 11..2 are copied unchanged to slot_req_n_o[9:0], so that slot_req_n_o[j] is the active-low request for output slot 12-j. They are loaded at the end of slot 1 whatever the ready flag says, and held until the end of the next slot 1.
- R6: Slot 1 bits 18..12 are the echoed 7-bit index. When it equals the address from the most recent rd_issue_i pulse while a read is pending, stat_data_o takes slot 2 bits 19..4 and stat_idx_o takes the index. stat_vld_o is high for the one bit clock right after frame bit 55 is sampled.
- R7: A pulse on rd_issue_i sets rd_pend_o and records rd_addr_i. A status capture clears rd_pend_o. Once it is clear, or when the index does not match, an echo produces no status strobe.
- R8: Slots 3, 4 and 6 (last bits at frame bits 75, 95 and 135) yield left_o, right_o and mic_o from slot bits 19..4. Bits 3..0 are ignored. The matching strobe is high for the one bit clock after that last bit.
- R9: A sync rise when the previous bit was not frame bit 255 of a locked frame pulses frame_err_o for one bit clock. The new frame starts at bit 0 and is captured normally.
- R10: Every valid strobe lasts exactly one bit clock per capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Link bit clock; the block samples and registers on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync; a rising edge marks frame bit 0 |
| sdin_i | input | 1 | Serial data from the codec |
| rd_addr_i | input | 7 | Register address of the read command being issued |
| rd_issue_i | input | 1 | One-cycle strobe recording rd_addr_i as the outstanding read |
| codec_rdy_o | output | 1 | Codec-ready flag of the current frame |
| slot_tag_o | output | 12 | Tag bits; bit k-1 belongs to slot k |
| slot_req_n_o | output | 10 | Held active-low output-slot request flags |
| rd_pend_o | output | 1 | A read is outstanding |
| stat_vld_o | output | 1 | Status capture strobe |
| stat_idx_o | output | 7 | Index of the captured status |
| stat_data_o | output | 16 | Captured status word |
| left_vld_o | output | 1 | Left sample strobe |
| left_o | output | 16 | Left record sample |
| right_vld_o | output | 1 | Right sample strobe |
| right_o | output | 16 | Right record sample |
| mic_vld_o | output | 1 | Microphone sample strobe |
| mic_o | output | 16 | Microphone sample |
| frame_err_o | output | 1 | Framing error pulse |

## Verification
The bench sends a second frame that echoes an index already matched. A design that leaves the read pending after a capture would accept that echo twice. The bench also sends a mismatched index, a frame with the codec not ready, and a frame with slot 2 untagged. A design that skipped the address, ready or tag qualification would strobe status data for each of them. The bench records the bit position of every strobe. An off-by-one slot boundary then shows up as a wrong position or a shifted value, and a sample with a non-zero low nibble catches the wrong bit range. It cuts a frame short at bit 60 and checks for exactly one error pulse followed by a cleanly captured frame. A counter that does not realign would misplace every later slot.

// File: rtl/acrx_pkg.sv
package acrx_pkg;
    localparam int HDR_BITS  = 16;
    localparam int SLOT_BITS = 20;
    localparam int NUM_SLOTS = 12;
    localparam int IDX_BITS  = 7;
    localparam int SMP_BITS  = 16;

    // position of the last bit of slot k within the frame
    function automatic int slot_last_bit(input int hdr_w, input int slot_w, input int k);
        return hdr_w - 1 + slot_w * k;
    endfunction
endpackage

// File: rtl/acrx_framer.sv
module acrx_framer #(
    parameter int FRAME_BITS = 256,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             bclk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    output logic [CNT_W-1:0] bit_idx_o,   // index of the bit sampled at this edge
    output logic [CNT_W-1:0] cnt_o,       // registered index
    output logic             locked_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             sync;
        logic [CNT_W-1:0] cnt;
        logic             locked;
        logic             err;
    } frm_st_t;

    frm_st_t st_q, st_d;
    logic    rise;

    always_comb begin
        st_d      = st_q;
        rise      = sync_i && !st_q.sync;
        st_d.sync = sync_i;
        st_d.err  = 1'b0;
        if (rise) begin
            st_d.cnt    = '0;
            st_d.locked = 1'b1;
            st_d.err    = st_q.locked && (st_q.cnt != LAST);
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(negedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_idx_o = st_d.cnt;
    assign cnt_o     = st_q.cnt;
    assign locked_o  = st_q.locked;
    assign err_o     = st_q.err;

    // R9: an error pulse always coincides with a realigned counter
    a_r9_err_realigns: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        st_q.err |-> (st_q.cnt == '0));
    // R9: an error pulse never lasts two bit clocks
    a_r9_err_pulse: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        st_q.err |=> !st_q.err);
endmodule

// File: rtl/acrx_shifter.sv
module acrx_shifter #(
    parameter int WIDTH = 20
) (
    input  logic             bclk_i,
    input  logic             rst_ni,
    input  logic             sdin_i,
    output logic [WIDTH-1:0] word_o    // includes the bit sampled at this edge
);
    typedef struct packed {
        logic [WIDTH-1:0] sh;
    } sh_st_t;

    sh_st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[WIDTH-2:0], sdin_i};
    end

    always_ff @(negedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_d.sh;
endmodule

// File: rtl/acrx_status.sv
module acrx_status #(
    parameter int IDX_W = 7,
    parameter int DAT_W = 16
) (
    input  logic             bclk_i,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] rd_addr_i,
    input  logic             rd_issue_i,
    input  logic             idx_ld_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             cap_i,
    input  logic [DAT_W-1:0] data_i,
    output logic             pend_o,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [DAT_W-1:0] data_o
);
    typedef struct packed {
        logic             pend;
        logic [IDX_W-1:0] addr;
        logic [IDX_W-1:0] echo;
        logic             vld;
        logic [IDX_W-1:0] sidx;
        logic [DAT_W-1:0] data;
    } st_st_t;

    st_st_t st_q, st_d;
    logic   hit;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        hit      = cap_i && st_q.pend && (st_q.echo == st_q.addr);
        if (idx_ld_i) begin
            st_d.echo = idx_i;
        end
        if (hit) begin
            st_d.vld  = 1'b1;
            st_d.sidx = st_q.echo;
            st_d.data = data_i;
            st_d.pend = 1'b0;
        end
        if (rd_issue_i) begin
            st_d.pend = 1'b1;
            st_d.addr = rd_addr_i;
        end
    end

    always_ff @(negedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign vld_o  = st_q.vld;
    assign idx_o  = st_q.sidx;
    assign data_o = st_q.data;

    // R7: a capture needs an outstanding read
    a_r7_needs_pending: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        st_q.vld |-> $past(st_q.pend));
    // R7: a capture retires the outstanding read unless a new one was issued
    a_r7_capture_clears: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        (st_q.vld && !$past(rd_issue_i)) |-> !st_q.pend);
    // R10: status strobe lasts one bit clock
    a_r10_stat_single: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        st_q.vld |=> !st_q.vld);
endmodule

// File: rtl/acrx_pcm_chan.sv
module acrx_pcm_chan #(
    parameter int DAT_W = 16
) (
    input  logic             bclk_i,
    input  logic             rst_ni,
    input  logic             cap_i,
    input  logic [DAT_W-1:0] data_i,
    output logic             vld_o,
    output logic [DAT_W-1:0] data_o
);
    typedef struct packed {
        logic             vld;
        logic [DAT_W-1:0] data;
    } ch_st_t;

    ch_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = cap_i;
        if (cap_i) begin
            st_d.data = data_i;
        end
    end

    always_ff @(negedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign data_o = st_q.data;

    // R10: sample strobe lasts one bit clock
    a_r10_pcm_single: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        st_q.vld |=> !st_q.vld);
endmodule

// File: rtl/acrx_top.sv
module acrx_top #(
    parameter int HDR_W  = acrx_pkg::HDR_BITS,
    parameter int SLOT_W = acrx_pkg::SLOT_BITS,
    parameter int NSLOT  = acrx_pkg::NUM_SLOTS,
    parameter int IDX_W  = acrx_pkg::IDX_BITS,
    parameter int SMP_W  = acrx_pkg::SMP_BITS
) (
    input  logic             bclk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic             sdin_i,
    input  logic [IDX_W-1:0] rd_addr_i,
    input  logic             rd_issue_i,
    output logic             codec_rdy_o,
    output logic [NSLOT-1:0] slot_tag_o,
    output logic [NSLOT-3:0] slot_req_n_o,
    output logic             rd_pend_o,
    output logic             stat_vld_o,
    output logic [IDX_W-1:0] stat_idx_o,
    output logic [SMP_W-1:0] stat_data_o,
    output logic             left_vld_o,
    output logic [SMP_W-1:0] left_o,
    output logic             right_vld_o,
    output logic [SMP_W-1:0] right_o,
    output logic             mic_vld_o,
    output logic [SMP_W-1:0] mic_o,
    output logic             frame_err_o
);
    import acrx_pkg::*;

    localparam int FRAME_BITS = HDR_W + NSLOT * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int REQ_W      = NSLOT - 2;
    localparam int NCH        = 3;
    localparam int CH_SLOT [NCH] = '{3, 4, 6};

    logic [CNT_W-1:0]  bit_idx, cnt_q;
    logic              locked, err;
    logic [SLOT_W-1:0] word;
    logic [NSLOT:0]    end_hit;

    acrx_framer #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_frm (
        .bclk_i   (bclk_i),
        .rst_ni   (rst_ni),
        .sync_i   (sync_i),
        .bit_idx_o(bit_idx),
        .cnt_o    (cnt_q),
        .locked_o (locked),
        .err_o    (err)
    );

    acrx_shifter #(.WIDTH(SLOT_W)) u_sh (
        .bclk_i(bclk_i),
        .rst_ni(rst_ni),
        .sdin_i(sdin_i),
        .word_o(word)
    );

    for (genvar k = 0; k <= NSLOT; k++) begin : g_end
        assign end_hit[k] = locked && (bit_idx == CNT_W'(slot_last_bit(HDR_W, SLOT_W, k)));
    end

    // header and request registers
    typedef struct packed {
        logic             rdy;
        logic [NSLOT-1:0] tags;
        logic [REQ_W-1:0] req_n;
    } hdr_st_t;

    hdr_st_t hd_q, hd_d;

    always_comb begin
        hd_d = hd_q;
        if (end_hit[0]) begin
            hd_d.rdy = word[HDR_W-1];
            for (int k = 1; k <= NSLOT; k++) begin
                hd_d.tags[k-1] = word[HDR_W-1-k];
            end
        end
        if (end_hit[1]) begin
            hd_d.req_n = word[REQ_W+1:2];
        end
    end

    always_ff @(negedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hd_q       <= '0;
            hd_q.req_n <= '1;
        end else begin
            hd_q <= hd_d;
        end
    end

    // status path
    logic stat_cap;
    assign stat_cap = end_hit[2] && hd_q.rdy && hd_q.tags[0] && hd_q.tags[1];

    acrx_status #(.IDX_W(IDX_W), .DAT_W(SMP_W)) u_stat (
        .bclk_i    (bclk_i),
        .rst_ni    (rst_ni),
        .rd_addr_i (rd_addr_i),
        .rd_issue_i(rd_issue_i),
        .idx_ld_i  (end_hit[1]),
        .idx_i     (word[SLOT_W-2 -: IDX_W]),
        .cap_i     (stat_cap),
        .data_i    (word[SLOT_W-1 -: SMP_W]),
        .pend_o    (rd_pend_o),
        .vld_o     (stat_vld_o),
        .idx_o     (stat_idx_o),
        .data_o    (stat_data_o)
    );

    // sample channels
    logic [NCH-1:0]  ch_vld;
    logic [SMP_W-1:0] ch_dat [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic cap;
        assign cap = end_hit[CH_SLOT[c]] && hd_q.rdy && hd_q.tags[CH_SLOT[c]-1];

        acrx_pcm_chan #(.DAT_W(SMP_W)) u_ch (
            .bclk_i(bclk_i),
            .rst_ni(rst_ni),
            .cap_i (cap),
            .data_i(word[SLOT_W-1 -: SMP_W]),
            .vld_o (ch_vld[c]),
            .data_o(ch_dat[c])
        );

        // R4: a sample strobe implies its slot was tagged
        a_r4_tagged: assert property (@(negedge bclk_i) disable iff (!rst_ni)
            ch_vld[c] |-> hd_q.tags[CH_SLOT[c]-1]);
        // R8: strobe follows the last bit of its slot
        a_r8_position: assert property (@(negedge bclk_i) disable iff (!rst_ni)
            ch_vld[c] |-> (cnt_q == CNT_W'(slot_last_bit(HDR_W, SLOT_W, CH_SLOT[c]))));
    end

    assign left_vld_o  = ch_vld[0];
    assign left_o      = ch_dat[0];
    assign right_vld_o = ch_vld[1];
    assign right_o     = ch_dat[1];
    assign mic_vld_o   = ch_vld[2];
    assign mic_o       = ch_dat[2];

    assign codec_rdy_o  = hd_q.rdy;
    assign slot_tag_o   = hd_q.tags;
    assign slot_req_n_o = hd_q.req_n;
    assign frame_err_o  = err;

    // R3: no capture strobe while the codec is not ready
    a_r3_ready_gates: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        (stat_vld_o || (|ch_vld)) |-> hd_q.rdy);
    // R2: nothing is captured before frame lock
    a_r2_locked_only: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        (stat_vld_o || (|ch_vld)) |-> locked);
    // R4: status strobe implies slots 1 and 2 tagged
    a_r4_stat_tags: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        stat_vld_o |-> (hd_q.tags[0] && hd_q.tags[1]));
    // R5: request flags change only at the end of slot 1
    a_r5_req_hold: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        !$stable(hd_q.req_n) |-> (cnt_q == CNT_W'(slot_last_bit(HDR_W, SLOT_W, 1))));
    // R6: status strobe follows the last bit of slot 2
    a_r6_stat_position: assert property (@(negedge bclk_i) disable iff (!rst_ni)
        stat_vld_o |-> (cnt_q == CNT_W'(slot_last_bit(HDR_W, SLOT_W, 2))));
endmodule

// File: tb/sim_acrx_top.sv
module sim_acrx_top;
    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        sdin = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic        rd_issue = 1'b0;
    logic        codec_rdy, rd_pend, stat_vld, left_vld, right_vld, mic_vld, frame_err;
    logic [11:0] slot_tag;
    logic [9:0]  slot_req_n;
    logic [6:0]  stat_idx;
    logic [15:0] stat_data, left, right, mic;

    always #4 bclk = ~bclk;   // 125 MHz

    acrx_top u0 (
        .bclk_i(bclk), .rst_ni(rst_n), .sync_i(sync), .sdin_i(sdin),
        .rd_addr_i(rd_addr), .rd_issue_i(rd_issue),
        .codec_rdy_o(codec_rdy), .slot_tag_o(slot_tag), .slot_req_n_o(slot_req_n),
        .rd_pend_o(rd_pend), .stat_vld_o(stat_vld), .stat_idx_o(stat_idx),
        .stat_data_o(stat_data), .left_vld_o(left_vld), .left_o(left),
        .right_vld_o(right_vld), .right_o(right), .mic_vld_o(mic_vld), .mic_o(mic),
        .frame_err_o(frame_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        rdy;
        logic [11:0] tags;
        logic [6:0]  idx;
        logic [9:0]  req;
        logic [15:0] sdat;
        logic [19:0] l;
        logic [19:0] r;
        logic [19:0] m;
        logic        issue;
        logic [6:0]  raddr;
        logic        exp_stat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{1'b1, 12'hFFF, 7'h26, 10'h000, 16'hBEEF, 20'hABCD0, 20'h12345, 20'hFEDC0, 1'b1, 7'h26, 1'b1},
        '{1'b1, 12'hFFF, 7'h26, 10'h155, 16'h1111, 20'h0F0F0, 20'h70000, 20'h00010, 1'b0, 7'h00, 1'b0},
        '{1'b1, 12'h024, 7'h12, 10'h3F0, 16'h2222, 20'h55550, 20'hAAAA0, 20'h33330, 1'b1, 7'h11, 1'b0},
        '{1'b0, 12'hFFF, 7'h11, 10'h00F, 16'h3333, 20'h44440, 20'h66660, 20'h77770, 1'b0, 7'h00, 1'b0},
        '{1'b1, 12'h001, 7'h11, 10'h2AA, 16'h4444, 20'h88880, 20'h99990, 20'hCCCC0, 1'b0, 7'h00, 1'b0},
        '{1'b1, 12'h003, 7'h11, 10'h3FF, 16'hC0DE, 20'hDDDD0, 20'hEEEE0, 20'h11110, 1'b0, 7'h00, 1'b1},
        '{1'b1, 12'h00B, 7'h7F, 10'h001, 16'hF00D, 20'h80000, 20'h8000F, 20'h22220, 1'b1, 7'h7F, 1'b1}
    };

    // per-frame observations
    int          c_stat, c_l, c_r, c_m, c_err;
    int          p_stat, p_l, p_r, p_m, p_err;
    logic [15:0] v_stat, v_l, v_r, v_m;
    logic [6:0]  v_idx;

    task automatic send_frame(input vec_t v, input int nbits);
        logic [19:0] sl [13];
        for (int s = 0; s < 13; s++) sl[s] = 20'h5A5A5;
        sl[0] = '0;
        sl[0][15] = v.rdy;
        for (int k = 1; k <= 12; k++) sl[0][15-k] = v.tags[k-1];
        sl[1] = {1'b0, v.idx, v.req, 2'b00};
        sl[2] = {v.sdat, 4'h0};
        sl[3] = v.l;
        sl[4] = v.r;
        sl[6] = v.m;
        c_stat = 0; c_l = 0; c_r = 0; c_m = 0; c_err = 0;
        p_stat = -1; p_l = -1; p_r = -1; p_m = -1; p_err = -1;
        for (int b = 0; b < nbits; b++) begin
            @(posedge bclk);
            #1;
            if (b >= 1) begin
                if (stat_vld)  begin c_stat++; p_stat = b-1; v_stat = stat_data; v_idx = stat_idx; end
                if (left_vld)  begin c_l++; p_l = b-1; v_l = left; end
                if (right_vld) begin c_r++; p_r = b-1; v_r = right; end
                if (mic_vld)   begin c_m++; p_m = b-1; v_m = mic; end
                if (frame_err) begin c_err++; p_err = b-1; end
            end
            sync = (b < 16);
            if (b < 16) sdin = sl[0][15-b];
            else sdin = sl[(b-16)/20 + 1][19 - ((b-16) % 20)];
            rd_issue = (b == 0) && v.issue;
            rd_addr  = v.raddr;
        end
    endtask

    bit pend_m = 1'b0;

    initial begin
        // R1: reset state
        repeat (3) @(posedge bclk);
        #1;
        chk(codec_rdy == 0, "R1 codec_rdy", codec_rdy, 0);
        chk(slot_req_n == 10'h3FF, "R1 slot_req_n", slot_req_n, 10'h3FF);
        chk(slot_tag == 0 && rd_pend == 0 && frame_err == 0, "R1 tags/pend/err",
            {slot_tag, rd_pend, frame_err}, 0);
        chk({stat_vld, left_vld, right_vld, mic_vld} == 0, "R1 strobes",
            {stat_vld, left_vld, right_vld, mic_vld}, 0);
        @(posedge bclk);
        #1 rst_n = 1'b1;

        // R2: no capture before the first sync rise
        begin
            int seen = 0;
            for (int b = 0; b < 300; b++) begin
                @(posedge bclk);
                #1;
                if (stat_vld || left_vld || right_vld || mic_vld || frame_err) seen++;
                sdin = 1'b1;
                sync = 1'b0;
            end
            chk(seen == 0, "R2 strobes before lock", seen, 0);
            chk(codec_rdy == 0, "R2 ready before lock", codec_rdy, 0);
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit el, er, em;
            v = VT[i];
            send_frame(v, 256);
            if (v.issue) pend_m = 1'b1;
            if (v.exp_stat) pend_m = 1'b0;
            el = v.rdy && v.tags[2];
            er = v.rdy && v.tags[3];
            em = v.rdy && v.tags[5];
            chk(c_err == 0, "R9 no error on aligned frame", c_err, 0);
            chk(codec_rdy == v.rdy, "R3 codec_rdy", codec_rdy, v.rdy);
            chk(slot_tag == v.tags, "R4 slot_tag", slot_tag, v.tags);
            chk(slot_req_n == v.req, "R5 slot_req_n", slot_req_n, v.req);
            chk(rd_pend == pend_m, "R7 rd_pend", rd_pend, pend_m);
            chk(c_stat == int'(v.exp_stat), "R6 R7 status strobe count", c_stat, v.exp_stat);
            if (v.exp_stat) begin
                chk(p_stat == 55, "R6 status strobe position", p_stat, 55);
                chk(v_stat == v.sdat, "R6 status data", v_stat, v.sdat);
                chk(v_idx == v.idx, "R6 status index", v_idx, v.idx);
            end
            chk(c_l == int'(el), "R8 R10 left count", c_l, el);
            chk(c_r == int'(er), "R8 R10 right count", c_r, er);
            chk(c_m == int'(em), "R8 R10 mic count", c_m, em);
            if (el) begin
                chk(p_l == 75, "R8 left position", p_l, 75);
                chk(v_l == v.l[19:4], "R8 left data", v_l, v.l[19:4]);
            end
            if (er) begin
                chk(p_r == 95, "R8 right position", p_r, 95);
                chk(v_r == v.r[19:4], "R8 right data", v_r, v.r[19:4]);
            end
            if (em) begin
                chk(p_m == 135, "R8 mic position", p_m, 135);
                chk(v_m == v.m[19:4], "R8 mic data", v_m, v.m[19:4]);
            end
        end

        // R9: frame cut at bit 60, then a full frame
        begin
            vec_t v;
            v = VT[0];
            v.issue = 1'b0;
            v.exp_stat = 1'b0;
            send_frame(v, 60);
            chk(c_err == 0, "R9 no error inside cut frame", c_err, 0);
            v.l = 20'h3C3C0;
            send_frame(v, 256);
            chk(c_err == 1, "R9 error pulse count", c_err, 1);
            chk(p_err == 0, "R9 error position", p_err, 0);
            chk(c_l == 1 && v_l == 16'h3C3C, "R9 resynced left capture", v_l, 16'h3C3C);
            chk(p_l == 75, "R9 resynced left position", p_l, 75);
            chk(c_stat == 0, "R7 no status without pending read", c_stat, 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule